// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and turns them into one encoded interrupt number for processor 0. A rising edge on a line sets a pending bit. If broadcast routing is enabled for that line, the edge instead sets the matching bit in the force register of every processor. Software can also force interrupts for a processor and mask them per processor. A level register divides the active interrupts into a high group and a low group. The high group is always served first. Within the chosen group, the highest-numbered active line wins.

All registers sit in a 256-byte window of 32-bit words. The upper address bits are ignored. The port is a simple single-cycle register port with valid, write, address and data signals. Read data comes back combinationally in the cycle of the read. When the processor takes an interrupt, it presents the interrupt number on an acknowledge input. This clears that source in the pending register and in processor 0's force register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset clears every register and drives the interrupt output to 0. Every register offset then reads 0.
- R2: Register byte offsets, with addresses taken modulo 256:
  - 0x00 is level.
  - 0x04 is pending, which is read-only.
  - 0x08 is the force register of processor 0, replaced whole on a write.
  - 0x0C is clear, which reads 0.
  - 0x10 is status, which reads 0 and ignores writes.
  - 0x14 is broadcast.
  - 0x40+4n is the mask of processor n.
  - 0x80+4n is the force register of processor n.
  - All other offsets read 0 and ignore writes.
- R3: Every register holds only bits 15:1. Bit 0 and bits 31:16 always read 0, and interrupt line 0 has no effect.
- R4: Writing the clear register clears each pending bit whose position is set in write data bits 15:1.
- R5: A write to offset 0x80+4n sets the force bits given in data bits 15:1 and clears those given in data bits 31:17. The new value is (old OR set) AND NOT clear.
- R6: A rising edge on line k sets pending bit k when broadcast bit k is 0. When broadcast bit k is 1, the edge sets force bit k of every processor. A line held high acts only once.
- R7: The effective set is (pending OR force of processor 0) AND mask of processor 0. The high group is the effective set AND level. If the high group is nonempty it is chosen; otherwise the low group (the remaining effective bits) is chosen.
- R8: The output is the index of the highest set bit of the chosen group, or 0 when that group is empty. It is registered, so it reflects an event at the clock edge that applies the event.
- R9: An acknowledge with number n clears bit n of pending and bit n of processor 0's force register.
- R10: Within one cycle, the register write applies first, then input edges set their bits, then the acknowledge clears. So an edge outlasts a same-cycle clear write but not a same-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt request lines; bit 0 unused |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_num | input | 4 | Number of the acknowledged interrupt |
| irq_req | output | 4 | Requested interrupt number, 0 for none |

## Verification
The hardest case to reach from the ports is a collision in a single cycle between software and hardware on the same bit. One collision is a clear write against a new edge. The other is an acknowledge against a new edge. Reaching either needs a line to be low, then rise exactly in the cycle of the competing access, while its pending bit is already set. The stimulus drives the register port, the request lines and the acknowledge from one per-cycle task, so that all three can land on the same edge. Around these cases, sweeps cover every pair of forced lines against several level patterns, every single-bit mask hole, and every acknowledge number. After each phase, all 64 word offsets are read back.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int IRQ_W = 16;
    localparam int ID_W  = $clog2(IRQ_W);
    localparam logic [IRQ_W-1:0] KEEP = {{(IRQ_W-1){1'b1}}, 1'b0};

    // word indices (byte offset / 4) inside the 256-byte window
    localparam logic [5:0] W_LEVEL  = 6'h00;
    localparam logic [5:0] W_PEND   = 6'h01;
    localparam logic [5:0] W_FALIAS = 6'h02;
    localparam logic [5:0] W_CLEAR  = 6'h03;
    localparam logic [5:0] W_STATUS = 6'h04;
    localparam logic [5:0] W_BCAST  = 6'h05;
    localparam logic [5:0] W_MASK0  = 6'h10;
    localparam logic [5:0] W_FORCE0 = 6'h20;
endpackage

// File: rtl/irqc_edge.sv
`timescale 1ns/1ps
module irqc_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    output logic [W-1:0] rise
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prev_d, prev_q;
        always_comb prev_d = lines[i];
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= prev_d;
        end
        assign rise[i] = lines[i] & ~prev_q;
    end
endmodule

// File: rtl/irqc_prio.sv
`timescale 1ns/1ps
module irqc_prio #(
    parameter int W   = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  eff,
    input  logic [W-1:0]  level,
    output logic [IW-1:0] num
);
    logic [W-1:0] hi, lo, sel;

    always_comb begin
        hi  = eff & level;
        lo  = eff & ~level;
        sel = (|hi) ? hi : lo;
        num = '0;
        for (int i = 0; i < W; i++) begin
            if (sel[i]) num = IW'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU   = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_W-1:0]  irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ack_valid,
    input  logic [ID_W-1:0]   ack_num,
    output logic [ID_W-1:0]   irq_req
);
    typedef struct packed {
        logic [IRQ_W-1:0]            level;
        logic [IRQ_W-1:0]            pend;
        logic [IRQ_W-1:0]            bcast;
        logic [NCPU-1:0][IRQ_W-1:0]  mask;
        logic [NCPU-1:0][IRQ_W-1:0]  frc;
    } state_t;

    state_t            st_d, st_q;
    logic [ID_W-1:0]   req_d, req_q;
    logic [IRQ_W-1:0]  rise, rise_m, wset, wclr, eff_d;
    logic [5:0]        widx;
    logic              wr, rd;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[ADDR_W-1:8], bus_addr[1:0]};

    irqc_edge #(.W(IRQ_W)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .rise  (rise)
    );

    always_comb begin
        widx   = bus_addr[7:2];
        wr     = bus_valid & bus_write;
        wset   = bus_wdata[IRQ_W-1:0] & KEEP;
        wclr   = bus_wdata[31:16] & KEEP;
        rise_m = rise & KEEP;
        st_d   = st_q;

        // step 1: register write
        if (wr) begin
            case (widx)
                W_LEVEL:  st_d.level  = wset;
                W_FALIAS: st_d.frc[0] = wset;
                W_CLEAR:  st_d.pend   = st_q.pend & ~wset;
                W_BCAST:  st_d.bcast  = wset;
                default: begin
                    for (int n = 0; n < NCPU; n++) begin
                        if (widx == 6'(W_MASK0 + 6'(n)))
                            st_d.mask[n] = wset;
                        if (widx == 6'(W_FORCE0 + 6'(n)))
                            st_d.frc[n] = (st_q.frc[n] | wset) & ~wclr;
                    end
                end
            endcase
        end

        // step 2: request edges
        st_d.pend = st_d.pend | (rise_m & ~st_d.bcast);
        for (int n = 0; n < NCPU; n++) begin
            st_d.frc[n] = st_d.frc[n] | (rise_m & st_d.bcast);
        end

        // step 3: acknowledge
        if (ack_valid) begin
            st_d.pend[ack_num]   = 1'b0;
            st_d.frc[0][ack_num] = 1'b0;
        end

        eff_d = (st_d.pend | st_d.frc[0]) & st_d.mask[0];
    end

    irqc_prio #(.W(IRQ_W)) i_prio (
        .eff   (eff_d),
        .level (st_d.level),
        .num   (req_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            req_q <= '0;
        end else begin
            st_q  <= st_d;
            req_q <= req_d;
        end
    end

    assign irq_req = req_q;

    always_comb begin
        rd        = bus_valid & ~bus_write;
        bus_rdata = '0;
        if (rd) begin
            case (widx)
                W_LEVEL:  bus_rdata[IRQ_W-1:0] = st_q.level;
                W_PEND:   bus_rdata[IRQ_W-1:0] = st_q.pend;
                W_FALIAS: bus_rdata[IRQ_W-1:0] = st_q.frc[0];
                W_BCAST:  bus_rdata[IRQ_W-1:0] = st_q.bcast;
                W_CLEAR, W_STATUS: bus_rdata = '0;
                default: begin
                    for (int n = 0; n < NCPU; n++) begin
                        if (widx == 6'(W_MASK0 + 6'(n)))
                            bus_rdata[IRQ_W-1:0] = st_q.mask[n];
                        if (widx == 6'(W_FORCE0 + 6'(n)))
                            bus_rdata[IRQ_W-1:0] = st_q.frc[n];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [5:0]       addr_word,
    input logic             ack_valid,
    input logic [ID_W-1:0]  ack_num,
    input logic [ID_W-1:0]  irq_req,
    input logic [IRQ_W-1:0] rise,
    input logic [IRQ_W-1:0] pend_q,
    input logic [IRQ_W-1:0] frc0_q,
    input logic [IRQ_W-1:0] mask0_q,
    input logic [IRQ_W-1:0] level_q
);
    logic [IRQ_W-1:0] eff;
    assign eff = (pend_q | frc0_q) & mask0_q;

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (!pend_q[$past(ack_num)] && !frc0_q[$past(ack_num)]));

    a_r3_bit0_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !frc0_q[0] && !mask0_q[0] && !level_q[0]);

    a_r8_req_is_active: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |-> eff[irq_req]);

    a_r8_none_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == '0) |-> (irq_req == '0));

    a_r7_high_group_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req != '0) && (|(eff & level_q))) |-> level_q[irq_req]);

    a_r2_pending_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && addr_word == W_PEND && rise == '0 && !ack_valid)
            |=> $stable(pend_q));
endmodule

bind irq_prio_ctrl irqc_checker i_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .addr_word (bus_addr[7:2]),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .irq_req   (irq_req),
    .rise      (rise),
    .pend_q    (st_q.pend),
    .frc0_q    (st_q.frc[0]),
    .mask0_q   (st_q.mask[0]),
    .level_q   (st_q.level)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    localparam int NCPU   = 2;
    localparam int ADDR_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic [3:0]  irq_req;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [15:0] m_lvl, m_pend, m_bc, m_prev;
    logic [15:0] m_mask [NCPU];
    logic [15:0] m_frc  [NCPU];

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.NCPU(NCPU), .ADDR_W(ADDR_W)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_num(ack_num), .irq_req(irq_req)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lvl = '0; m_pend = '0; m_bc = '0; m_prev = '0;
        for (int n = 0; n < NCPU; n++) begin
            m_mask[n] = '0; m_frc[n] = '0;
        end
    endtask

    function automatic logic [3:0] exp_req();
        logic [15:0] eff, hi, sel;
        logic [3:0]  r;
        eff = (m_pend | m_frc[0]) & m_mask[0];
        hi  = eff & m_lvl;
        sel = (hi != 0) ? hi : (eff & ~m_lvl);
        r = 0;
        for (int i = 1; i < 16; i++) if (sel[i]) r = 4'(i);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input int w);
        logic [31:0] v;
        v = '0;
        case (w)
            0: v[15:0] = m_lvl;
            1: v[15:0] = m_pend;
            2: v[15:0] = m_frc[0];
            5: v[15:0] = m_bc;
            default: begin
                if (w >= 16 && w < 16 + NCPU) v[15:0] = m_mask[w-16];
                if (w >= 32 && w < 32 + NCPU) v[15:0] = m_frc[w-32];
            end
        endcase
        return v;
    endfunction

    // one clock of stimulus; reference follows the order write, edges, acknowledge (R10)
    task automatic cyc(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [15:0] irq,
                       input bit av, input logic [3:0] an, input string tag);
        logic [15:0] s, c, e;
        int wi;
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        irq_in = irq; ack_valid = av; ack_num = an;
        s  = d[15:0] & 16'hFFFE;
        c  = d[31:16] & 16'hFFFE;
        wi = int'(a[7:2]);
        if (v && w) begin
            case (wi)
                0: m_lvl = s;
                2: m_frc[0] = s;
                3: m_pend = m_pend & ~s;
                5: m_bc = s;
                default: begin
                    if (wi >= 16 && wi < 16 + NCPU) m_mask[wi-16] = s;
                    if (wi >= 32 && wi < 32 + NCPU) m_frc[wi-32] = (m_frc[wi-32] | s) & ~c;
                end
            endcase
        end
        e = irq & ~m_prev & 16'hFFFE;
        m_prev = irq;
        m_pend = m_pend | (e & ~m_bc);
        for (int n = 0; n < NCPU; n++) m_frc[n] = m_frc[n] | (e & m_bc);
        if (av) begin
            m_pend[an] = 1'b0;
            m_frc[0][an] = 1'b0;
        end
        @(posedge clk);
        #1;
        check({28'd0, irq_req}, {28'd0, exp_req()}, tag);
        bus_valid = 1'b0; ack_valid = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, irq_in, 1'b0, 4'd0, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int w = 0; w < 64; w++) begin
            @(negedge clk);
            bus_valid = 1'b1; bus_write = 1'b0;
            bus_addr = ADDR_W'(w * 4 + 12'h300);  // upper bits must be ignored
            #1;
            check(bus_rdata, exp_read(w), tag);
            bus_valid = 1'b0;
        end
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({28'd0, irq_req}, 32'd0, "R1 output after reset");
        rst_n = 1'b1;
        rd_all("R1 reset register state");

        // R2, R3: write masking, read-only and unmapped offsets, address wrap
        wr(12'h000, 32'hFFFF_FFFF, "R3 level write");
        wr(12'h014, 32'h0001_0001, "R3 broadcast bit0");
        wr(12'h004, 32'h0000_FFFE, "R2 pending write ignored");
        wr(12'h010, 32'hFFFF_FFFF, "R2 status write ignored");
        wr(12'h018, 32'hFFFF_FFFF, "R2 unmapped write");
        wr(12'h048, 32'hFFFF_FFFF, "R2 mask of absent cpu");
        wr(12'h140, 32'h0000_00F1, "R2 wrapped mask write");
        wr(12'h044, 32'h0000_1234, "R2 mask cpu1");
        rd_all("R2 R3 register map");

        // R7, R8: every pair of forced lines with three level patterns
        wr(12'h040, 32'h0000_FFFF, "R7 mask all");
        for (int i = 1; i < 16; i++) begin
            for (int j = 1; j < 16; j++) begin
                wr(12'h000, 32'h0, "R8 level clear");
                wr(12'h008, (32'd1 << i) | (32'd1 << j), "R8 pair forced");
                wr(12'h000, 32'd1 << i, "R7 level on i");
                wr(12'h000, 32'd1 << j, "R7 level on j");
            end
        end
        // R7: single mask holes
        wr(12'h000, 32'h0, "R7 level clear");
        wr(12'h008, 32'h0000_FFFF, "R7 force all");
        for (int k = 1; k < 16; k++) wr(12'h040, ~(32'd1 << k), "R7 mask hole");
        wr(12'h008, 32'h0, "R8 force none");
        rd_all("R7 after sweeps");

        // R6, R4: edges set pending once; clear removes them while held
        wr(12'h040, 32'h0000_FFFE, "R6 mask all");
        wr(12'h014, 32'h0, "R6 broadcast off");
        for (int k = 0; k < 16; k++) begin
            cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'd1 << k, 1'b0, 4'd0, "R6 rising edge");
            cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'd1 << k, 1'b0, 4'd0, "R6 held high");
            wr(12'h00C, 32'd1 << k, "R4 clear pending");
            cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'd1 << k, 1'b0, 4'd0, "R6 no re-trigger");
            cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R6 line low");
        end
        rd_all("R6 after edge sweep");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'hFFFF, 1'b0, 4'd0, "R6 all lines");
        wr(12'h00C, 32'h0000_5A5A, "R4 partial clear");
        rd_all("R4 partial clear");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R6 all low");

        // R6: broadcast routing
        wr(12'h014, 32'h0000_AAAA, "R6 broadcast set");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'hFFFF, 1'b0, 4'd0, "R6 broadcast edges");
        rd_all("R6 broadcast routing");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R6 lines low");

        // R5: set and clear in one write
        wr(12'h084, 32'h00F0_0F0F, "R5 cpu1 set/clear");
        wr(12'h080, 32'h0300_0F0E, "R5 cpu0 set/clear");
        wr(12'h080, 32'hFFFF_0000, "R5 cpu0 clear all");
        wr(12'h080, 32'h0000_8002, "R5 cpu0 set two");
        rd_all("R5 force registers");

        // R9: acknowledge every number
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'hFFFF, 1'b0, 4'd0, "R9 load");
        wr(12'h008, 32'h0000_FFFE, "R9 force all");
        for (int n = 15; n >= 0; n--)
            cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'hFFFF, 1'b1, 4'(n), "R9 acknowledge");
        rd_all("R9 after acknowledges");

        // R10: same-cycle collisions
        wr(12'h014, 32'h0, "R10 broadcast off");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R10 lines low");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0020, 1'b0, 4'd0, "R10 set bit5");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R10 drop line");
        cyc(1'b1, 1'b1, 12'h00C, 32'h0000_0020, 16'h0020, 1'b0, 4'd0, "R10 edge beats clear");
        rd_all("R10 edge beats clear");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0, 1'b0, 4'd0, "R10 drop line");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0020, 1'b1, 4'd5, "R10 ack beats edge");
        rd_all("R10 ack beats edge");
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'h0001, 1'b0, 4'd0, "R3 line 0 ignored");
        rd_all("R3 line 0 ignored");

        // R1: reset again from a busy state
        cyc(1'b0, 1'b0, 12'h0, 32'h0, 16'hF0F0, 1'b0, 4'd0, "R1 busy");
        @(negedge clk);
        rst_n = 1'b0;
        irq_in = '0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({28'd0, irq_req}, 32'd0, "R1 output after second reset");
        rd_all("R1 second reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule